// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static Memory

This block is a word-organised static memory with sixteen data bits split into two byte lanes. It is controlled the way an asynchronous memory device is: one chip select is active low and a second is active high, and the part is selected only when both are asserted. Write enable and output enable are both active low. Each byte lane has its own active-low enable. The storage is built from clocked registers. A write condition that is present at a rising clock edge stores the enabled bytes at the addressed word. Read data reaches the output combinationally from the array.

The bidirectional data pins of a real device are split here. There is a 16-bit input bus and a 16-bit output bus, plus one drive flag per lane that marks when that lane would leave high impedance. A lane that is not driven shows zero on the output bus. A standby flag is raised whenever the part is deselected, or when it is selected with both byte enables inactive.

The address port is 19 bits wide. The number of implemented words is a power-of-two parameter, so the array can be made small for test. Address bits above the implemented depth are ignored. An active-low reset blocks writes while it is held. The stored contents are never cleared.

Top module: `dualSelSram`

## Requirements
- R1: When cs1N is 0, cs2 is 1, weN is 0 and at least one byte enable is 0 at a rising clock edge, the enabled bytes of dataIn are stored at the addressed word. The value of oeN has no influence on this.
- R2: When cs1N is 1 or cs2 is 0, standby is 1, both drive flags are 0, and no write takes place.
- R3: When the part is selected with lbN and ubN both 1, standby is 1, both drive flags are 0, and no write takes place even if weN is 0.
- R4: A read is weN 1 and oeN 0 while selected. Bits 7:0 of dataOut carry the stored lower byte and laneDriveLo is 1 only when lbN is 0. Bits 15:8 carry the stored upper byte and laneDriveHi is 1 only when ubN is 0. The data follows the address and the enables in the same cycle.
- R5: While weN is 0 and the part is selected, neither drive flag is 1.
- R6: When the part is selected with weN 1, oeN 1 and at least one byte enable 0, both drive flags are 0 and standby is 0.
- R7: Each byte of dataOut whose drive flag is 0 reads as zero.
- R8: Only the low DEPTH_LOG2 address bits select a word. Addresses that differ only in higher bits reach the same word.
- R9: While rstN is 0, no write takes effect.
- R10: A byte lane whose enable is 1 during a write keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the write condition |
| rstN | input | 1 | Active-low reset; blocks writes while low |
| addr | input | 19 | Word address |
| cs1N | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| lbN | input | 1 | Active-low enable for bits 7:0 |
| ubN | input | 1 | Active-low enable for bits 15:8 |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Read data; undriven lanes are zero |
| laneDriveLo | output | 1 | Lower lane would be driven |
| laneDriveHi | output | 1 | Upper lane would be driven |
| standby | output | 1 | Deselected, or selected with no lane enabled |

## Verification
The bench writes single bytes into words that already hold known data. A design that ignored the lane enables would overwrite the neighbouring byte, and a design that swapped the lanes would return the byte in the wrong half. Writes are attempted while deselected, while both byte enables are high, and while reset is held; a design that leaked any of these would change data that is read back afterwards. Every control row is checked for drive flags and standby, including the write row with output enable low, where a careless read decode would drive the bus against incoming data. An address with bits set above the implemented depth must reach the same word as its low bits alone; a design that used the wrong bits would return a different value.

// File: rtl/sramPkg.sv
package sramPkg;
  localparam int LANES = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic [LANES-1:0] laneWrite;
    logic [LANES-1:0] laneDrive;
    logic             standby;
  } ctlStrobes_t;
endpackage

// File: rtl/sramLaneCtl.sv
module sramLaneCtl
  import sramPkg::*;
(
  input  logic        rstN,
  input  logic        cs1N,
  input  logic        cs2,
  input  logic        weN,
  input  logic        oeN,
  input  logic        lbN,
  input  logic        ubN,
  output ctlStrobes_t strobes
);
  logic             selected;
  logic             anyLane;
  logic             writeCyc;
  logic             readCyc;
  logic [LANES-1:0] laneOn;

  always_comb begin
    laneOn   = {~ubN, ~lbN};
    selected = ~cs1N & cs2;
    anyLane  = |laneOn;
    writeCyc = selected & ~weN & anyLane & rstN;
    readCyc  = selected & weN & ~oeN;
    strobes.laneWrite = writeCyc ? laneOn : '0;
    strobes.laneDrive = readCyc ? laneOn : '0;
    strobes.standby   = ~selected | ~anyLane;
  end
endmodule

// File: rtl/sramLaneArray.sv
module sramLaneArray
  import sramPkg::*;
#(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  logic [DEPTH_LOG2-1:0] wordIdx,
  input  logic [DATA_W-1:0]     dataIn,
  input  ctlStrobes_t           strobes,
  output logic [DATA_W-1:0]     dataOut
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rdByte;

    always_ff @(posedge clk) begin
      if (strobes.laneWrite[lane])
        store[wordIdx] <= dataIn[lane*LANE_W +: LANE_W];
    end

    assign rdByte = store[wordIdx];
    assign dataOut[lane*LANE_W +: LANE_W] =
      strobes.laneDrive[lane] ? rdByte : '0;
  end
endmodule

// File: rtl/dualSelSram.sv
module dualSelSram
  import sramPkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs1N,
  input  logic              cs2,
  input  logic              weN,
  input  logic              oeN,
  input  logic              lbN,
  input  logic              ubN,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic              laneDriveLo,
  output logic              laneDriveHi,
  output logic              standby
);
  ctlStrobes_t strobes;

  sramLaneCtl ctl (
    .rstN(rstN), .cs1N(cs1N), .cs2(cs2), .weN(weN), .oeN(oeN),
    .lbN(lbN), .ubN(ubN), .strobes(strobes)
  );

  sramLaneArray #(.DEPTH_LOG2(DEPTH_LOG2)) array (
    .clk(clk), .wordIdx(addr[DEPTH_LOG2-1:0]), .dataIn(dataIn),
    .strobes(strobes), .dataOut(dataOut)
  );

  if (ADDR_W > DEPTH_LOG2) begin : gHighAddr
    logic unusedHighAddr;
    assign unusedHighAddr = ^addr[ADDR_W-1:DEPTH_LOG2];
  end

  assign laneDriveLo = strobes.laneDrive[0];
  assign laneDriveHi = strobes.laneDrive[1];
  assign standby     = strobes.standby;
endmodule

// File: rtl/dualSelSramChk.sv
module dualSelSramChk (
  input logic        clk,
  input logic        rstN,
  input logic        cs1N,
  input logic        cs2,
  input logic        weN,
  input logic        lbN,
  input logic        ubN,
  input logic [15:0] dataOut,
  input logic        laneDriveLo,
  input logic        laneDriveHi,
  input logic        standby
);
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cs1N || !cs2) |-> (standby && !laneDriveLo && !laneDriveHi)); // R2
  AST_NO_LANE_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    (lbN && ubN) |-> (standby && !laneDriveLo && !laneDriveHi)); // R3
  AST_LO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    laneDriveLo |-> !lbN); // R4
  AST_HI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    laneDriveHi |-> !ubN); // R4
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && !cs1N && cs2) |-> !(laneDriveLo || laneDriveHi)); // R5
  AST_LO_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !laneDriveLo |-> (dataOut[7:0] == 8'h00)); // R7
  AST_HI_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !laneDriveHi |-> (dataOut[15:8] == 8'h00)); // R7
endmodule

bind dualSelSram dualSelSramChk chk (
  .clk(clk), .rstN(rstN), .cs1N(cs1N), .cs2(cs2), .weN(weN),
  .lbN(lbN), .ubN(ubN), .dataOut(dataOut), .laneDriveLo(laneDriveLo),
  .laneDriveHi(laneDriveHi), .standby(standby)
);

// File: tb/dualSelSram_test.sv
module dualSelSram_test;
  localparam int ADDR_W = 19;
  localparam int DEPTH_LOG2 = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              cs1N = 1'b1;
  logic              cs2 = 1'b0;
  logic              weN = 1'b1;
  logic              oeN = 1'b1;
  logic              lbN = 1'b1;
  logic              ubN = 1'b1;
  logic [15:0]       dataIn = '0;
  logic [15:0]       dataOut;
  logic              laneDriveLo;
  logic              laneDriveHi;
  logic              standby;

  int compared = 0;
  int mismatched = 0;

  dualSelSram #(.ADDR_W(ADDR_W), .DEPTH_LOG2(DEPTH_LOG2)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .cs1N(cs1N), .cs2(cs2),
    .weN(weN), .oeN(oeN), .lbN(lbN), .ubN(ubN), .dataIn(dataIn),
    .dataOut(dataOut), .laneDriveLo(laneDriveLo),
    .laneDriveHi(laneDriveHi), .standby(standby)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs1N = 1'b1; cs2 = 1'b0; weN = 1'b1; oeN = 1'b1; lbN = 1'b1; ubN = 1'b1;
  endtask

  // one write cycle; drive flags are checked while the write is presented
  task automatic writeWord(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                           input logic lb, input logic ub, input logic oe);
    @(negedge clk);
    cs1N = 1'b0; cs2 = 1'b1; weN = 1'b0; oeN = oe; lbN = lb; ubN = ub;
    addr = a; dataIn = d;
    #1;
    chk("R5 drive flags during write", {laneDriveHi, laneDriveLo}, 2'b00);
    @(negedge clk);
    idle();
  endtask

  task automatic readCheck(input string tag, input logic [ADDR_W-1:0] a,
                           input logic lb, input logic ub, input logic [15:0] expData);
    @(negedge clk);
    cs1N = 1'b0; cs2 = 1'b1; weN = 1'b1; oeN = 1'b0; lbN = lb; ubN = ub; addr = a;
    #1;
    chk({tag, " data"}, dataOut, expData);
    chk({tag, " drive"}, {laneDriveHi, laneDriveLo}, {~ub, ~lb});
    chk({tag, " standby"}, standby, 1'b0);
    @(negedge clk);
    idle();
  endtask

  task automatic ctlRow(input string tag, input logic c1, input logic c2, input logic we,
                        input logic oe, input logic lb, input logic ub,
                        input logic [1:0] expDrive, input logic expStandby);
    @(negedge clk);
    cs1N = c1; cs2 = c2; weN = we; oeN = oe; lbN = lb; ubN = ub;
    #1;
    chk({tag, " drive"}, {laneDriveHi, laneDriveLo}, expDrive);
    chk({tag, " standby"}, standby, expStandby);
    if (expDrive == 2'b00) chk({tag, " R7 zero bus"}, dataOut, 16'h0000);
    @(negedge clk);
    idle();
  endtask

  task automatic testReset();
    #1;
    chk("reset standby", standby, 1'b1);
    chk("reset drive", {laneDriveHi, laneDriveLo}, 2'b00);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    writeWord(19'd5, 16'h1111, 1'b0, 1'b0, 1'b1);
    rstN = 1'b0;
    writeWord(19'd5, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    rstN = 1'b1;
    readCheck("R9 write under reset blocked", 19'd5, 1'b0, 1'b0, 16'h1111);
  endtask

  task automatic testWordWrite();
    writeWord(19'd20, 16'hBEEF, 1'b0, 1'b0, 1'b0);
    readCheck("R1 word write with oeN low", 19'd20, 1'b0, 1'b0, 16'hBEEF);
    writeWord(19'd21, 16'h4321, 1'b0, 1'b0, 1'b1);
    readCheck("R1 word write with oeN high", 19'd21, 1'b0, 1'b0, 16'h4321);
  endtask

  task automatic testByteWrite();
    writeWord(19'd10, 16'h1357, 1'b0, 1'b0, 1'b1);
    writeWord(19'd10, 16'hFFAA, 1'b0, 1'b1, 1'b1);
    readCheck("R10 lower-only write", 19'd10, 1'b0, 1'b0, 16'h13AA);
    writeWord(19'd10, 16'h55FF, 1'b1, 1'b0, 1'b1);
    readCheck("R10 upper-only write", 19'd10, 1'b0, 1'b0, 16'h55AA);
    readCheck("R4 lower lane read", 19'd10, 1'b0, 1'b1, 16'h00AA);
    readCheck("R4 upper lane read", 19'd10, 1'b1, 1'b0, 16'h5500);
  endtask

  task automatic testBlockedWrites();
    writeWord(19'd30, 16'h0F0F, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    cs1N = 1'b1; cs2 = 1'b1; weN = 1'b0; lbN = 1'b0; ubN = 1'b0; addr = 19'd30; dataIn = 16'hDEAD;
    @(negedge clk);
    cs1N = 1'b0; cs2 = 1'b0;
    @(negedge clk);
    idle();
    readCheck("R2 deselected write ignored", 19'd30, 1'b0, 1'b0, 16'h0F0F);
    @(negedge clk);
    cs1N = 1'b0; cs2 = 1'b1; weN = 1'b0; lbN = 1'b1; ubN = 1'b1; addr = 19'd30; dataIn = 16'hCAFE;
    @(negedge clk);
    idle();
    readCheck("R3 no-lane write ignored", 19'd30, 1'b0, 1'b0, 16'h0F0F);
  endtask

  task automatic testTruthRows();
    ctlRow("R2 cs1N high", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
    ctlRow("R2 cs2 low", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
    ctlRow("R3 both lanes off", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
    ctlRow("R6 output disabled", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    ctlRow("R5 write row oeN low", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    ctlRow("R4 read both lanes", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0);
  endtask

  task automatic testAlias();
    writeWord(19'h7F103, 16'h9A9A, 1'b0, 1'b0, 1'b1);
    readCheck("R8 high address bits ignored", 19'h00003, 1'b0, 1'b0, 16'h9A9A);
  endtask

  initial begin
    testReset();
    testWordWrite();
    testByteWrite();
    testBlockedWrites();
    testTruthRows();
    testAlias();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule